// File: doc/BRIEF.md
# Ping-pong chunked stream sequencer

The sequencer moves a circular sample buffer between memory and a word-wide peripheral port, one word per accepted handshake, in chunks of fixed size. Two chunk descriptors take turns: while one is active, the other already holds the following chunk. When a chunk finishes, the roles swap and the finished descriptor is reloaded with the next buffer offset. Each finished chunk raises a one-cycle event, so that a producer can refill the slot just sent or a consumer can drain the slot just filled. The stream wraps at the end of the buffer and runs until a stop command or a memory bus error.

The direction select picks the flow. In transmit, memory is read at an incrementing address and the word goes to a fixed peripheral port. In receive, words from the fixed port are written to memory at an incrementing address. A single-shot mode sends or captures the whole buffer once and then goes idle without any chunk events. Lengths are in bytes. The buffer length must be a nonzero multiple of the chunk length, and the chunk length must be a multiple of the word size; other values are not supported. Memory reads return data in the same cycle as the address.

Top module: `pingpong_stream_seq`

## Requirements
- R1: A start command is taken only while idle. In the next cycle the block is busy and its first access uses offset 0, the error flag is clear, and the end flag of the selected direction is clear.
- R2: While transmitting, memory is read every cycle at the current address and the read word is offered on the transmit port. The address moves up by WORD_BYTES only on a cycle where the port accepts, and otherwise holds.
- R3: While receiving, the receive port is ready. Each valid word is written to memory at the current address, and no write happens in a cycle without valid.
- R4: A chunk has chunk length divided by WORD_BYTES words. The chunk-done output is high for exactly one cycle, the cycle after the last word of each chunk.
- R5: The active slot output is 0 after start. It toggles at each chunk completion when the buffer holds two or more chunks, and stays 0 when the buffer holds one chunk.
- R6: After the word at offset buffer length minus WORD_BYTES, the next address is 0 and the stream continues.
- R7: A stop while busy makes the block idle in the next cycle and sets the end flag of the running direction. The next start begins again at offset 0.
- R8: A memory error on an access withdraws that word (transmit valid drops, the word is not counted). The block is idle in the next cycle and the error flag is set, holding until the next start.
- R9: In single-shot mode the block moves buffer length bytes once from offset 0 and then goes idle. It raises no chunk-done pulse and sets no end flag.
- R10: A start while busy is ignored, leaving the direction and the stream unchanged. A stop while idle changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (taken when idle) |
| stop_i | input | 1 | Halt a running transfer |
| dir_rx_i | input | 1 | 0 transmit from memory, 1 receive into memory |
| single_i | input | 1 | 1 selects single-shot mode at start |
| buf_len_i | input | LEN_W | Buffer length in bytes |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| mem_addr_o | output | LEN_W | Byte offset of the current memory access |
| mem_rd_o | output | 1 | Memory read request |
| mem_rdata_i | input | DW | Read data, same cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Write data |
| mem_err_i | input | 1 | Bus error on the current access |
| per_tx_valid_o | output | 1 | Transmit word offered |
| per_tx_data_o | output | DW | Transmit word |
| per_tx_ready_i | input | 1 | Peripheral accepts the transmit word |
| per_rx_valid_i | input | 1 | Peripheral offers a received word |
| per_rx_data_i | input | DW | Received word |
| per_rx_ready_o | output | 1 | Block accepts a received word |
| busy_o | output | 1 | Transfer running |
| slot_o | output | 1 | Index of the active descriptor |
| chunk_done_o | output | 1 | One-cycle chunk completion event |
| tx_end_o | output | 1 | Transmit stream ended by stop |
| rx_end_o | output | 1 | Receive stream ended by stop |
| error_o | output | 1 | Sticky bus error flag |

## Verification
Port handshakes and memory writes act on the same cycle they are offered, so the monitor compares each accepted word's address and data at the falling edge of that cycle. The chunk-done pulse and the slot change show up one cycle after the last word of a chunk, and the monitor checks the slot at the moment it sees the pulse. Start, stop and error outcomes are checked one clock after the command or faulting access. The driver changes inputs just after a rising edge and withdraws the handshake a cycle before a stop, so the number of words expected in the scoreboard queue is exact.

// File: rtl/pingpong_stream_seq.sv
module pingpong_stream_seq #(
  parameter int WORD_BYTES = 2,
  parameter int LEN_W      = 10,
  localparam int DW        = 8 * WORD_BYTES,
  localparam int WSH       = $clog2(WORD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             dir_rx_i,
  input  logic             single_i,
  input  logic [LEN_W-1:0] buf_len_i,
  input  logic [LEN_W-1:0] chunk_len_i,
  output logic [LEN_W-1:0] mem_addr_o,
  output logic             mem_rd_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_wr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_err_i,
  output logic             per_tx_valid_o,
  output logic [DW-1:0]    per_tx_data_o,
  input  logic             per_tx_ready_i,
  input  logic             per_rx_valid_i,
  input  logic [DW-1:0]    per_rx_data_i,
  output logic             per_rx_ready_o,
  output logic             busy_o,
  output logic             slot_o,
  output logic             chunk_done_o,
  output logic             tx_end_o,
  output logic             rx_end_o,
  output logic             error_o
);

  logic                  run_q, dir_q, single_q, err_q, tx_end_q, rx_end_q, done_q, cur_q;
  logic [1:0][LEN_W-1:0] slot_off_q;
  logic [1:0]            slot_vld_q;
  logic [LEN_W-1:0]      word_q, cw_q, next_off_q, chunk_q, len_q;
  logic                  tx_go, rx_go, bus_err, beat, last;

  function automatic logic [LEN_W-1:0] wrap_add(input logic [LEN_W-1:0] a, b, lim);
    logic [LEN_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= {1'b0, lim}) ? '0 : s[LEN_W-1:0];
  endfunction

  assign tx_go   = run_q & ~dir_q;
  assign rx_go   = run_q & dir_q;
  assign bus_err = (mem_rd_o | mem_wr_o) & mem_err_i;
  assign beat    = ~bus_err & ((tx_go & per_tx_ready_i) | (rx_go & per_rx_valid_i));
  assign last    = (word_q == cw_q - LEN_W'(1));

  assign mem_addr_o     = slot_off_q[cur_q] + (word_q << WSH);
  assign mem_rd_o       = tx_go;
  assign per_tx_valid_o = tx_go & ~mem_err_i;
  assign per_tx_data_o  = mem_rdata_i;
  assign per_rx_ready_o = rx_go;
  assign mem_wr_o       = rx_go & per_rx_valid_i;
  assign mem_wdata_o    = per_rx_data_i;

  assign busy_o       = run_q;
  assign slot_o       = cur_q;
  assign chunk_done_o = done_q;
  assign tx_end_o     = tx_end_q;
  assign rx_end_o     = rx_end_q;
  assign error_o      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      dir_q      <= 1'b0;
      single_q   <= 1'b0;
      err_q      <= 1'b0;
      tx_end_q   <= 1'b0;
      rx_end_q   <= 1'b0;
      done_q     <= 1'b0;
      cur_q      <= 1'b0;
      slot_off_q <= '0;
      slot_vld_q <= '0;
      word_q     <= '0;
      cw_q       <= '0;
      next_off_q <= '0;
      chunk_q    <= '0;
      len_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q         <= 1'b1;
          dir_q         <= dir_rx_i;
          single_q      <= single_i;
          err_q         <= 1'b0;
          if (dir_rx_i) rx_end_q <= 1'b0;
          else          tx_end_q <= 1'b0;
          cur_q         <= 1'b0;
          word_q        <= '0;
          chunk_q       <= chunk_len_i;
          len_q         <= buf_len_i;
          cw_q          <= (single_i ? buf_len_i : chunk_len_i) >> WSH;
          slot_off_q[0] <= '0;
          slot_off_q[1] <= chunk_len_i;
          slot_vld_q[0] <= 1'b1;
          slot_vld_q[1] <= ~single_i & (chunk_len_i < buf_len_i);
          next_off_q    <= (~single_i & (chunk_len_i < buf_len_i))
                           ? wrap_add(chunk_len_i, chunk_len_i, buf_len_i) : '0;
        end
      end else if (stop_i) begin
        run_q      <= 1'b0;
        single_q   <= 1'b0;
        word_q     <= '0;
        next_off_q <= '0;
        slot_off_q <= '0;
        if (dir_q) rx_end_q <= 1'b1;
        else       tx_end_q <= 1'b1;
      end else if (bus_err) begin
        run_q    <= 1'b0;
        single_q <= 1'b0;
        err_q    <= 1'b1;
        word_q   <= '0;
      end else if (beat) begin
        if (!last) begin
          word_q <= word_q + LEN_W'(1);
        end else begin
          word_q <= '0;
          if (single_q) begin
            run_q    <= 1'b0;
            single_q <= 1'b0;
          end else begin
            done_q            <= 1'b1;
            slot_off_q[cur_q] <= next_off_q;
            if (slot_vld_q[!cur_q]) cur_q <= ~cur_q;
            next_off_q        <= wrap_add(next_off_q, chunk_q, len_q);
          end
        end
      end
    end
  end

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !stop_i && !bus_err |=> $stable(dir_q));

  p_stop_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && stop_i |=> !busy_o && (tx_end_o || rx_end_o));

  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !stop_i && bus_err |=> !busy_o && error_o);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error_o && !start_i |=> error_o);

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go && !per_tx_ready_i && !stop_i && !mem_err_i |=> $stable(mem_addr_o));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !last && !stop_i |=> (mem_addr_o - $past(mem_addr_o)) == LEN_W'(WORD_BYTES));

  p_single_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |=> !chunk_done_o);

  p_slot_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && beat && last && !single_q && !stop_i && slot_vld_q[!cur_q] |=> slot_o != $past(slot_o));

endmodule

// File: tb/test_pingpong_stream_seq.sv
module test_pingpong_stream_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 2;
  localparam int LW = 10;
  localparam int DW = 8 * WB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, dir_rx = 0, single = 0;
  logic [LW-1:0] buf_len = '0, chunk_len = '0;
  logic [LW-1:0] mem_addr;
  logic mem_rd, mem_wr, mem_err;
  logic [DW-1:0] mem_rdata, mem_wdata, tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic busy, slot, chunk_done, tx_end, rx_end, error;
  logic err_en = 0;
  logic [LW-1:0] err_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [LW-1:0] a);
    return DW'(a) * DW'(37) + DW'(16'h1200);
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign mem_err   = err_en && (mem_addr == err_addr);

  pingpong_stream_seq #(.WORD_BYTES(WB), .LEN_W(LW)) i_pingpong_stream_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .dir_rx_i(dir_rx),
    .single_i(single), .buf_len_i(buf_len), .chunk_len_i(chunk_len),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_err_i(mem_err),
    .per_tx_valid_o(tx_valid), .per_tx_data_o(tx_data), .per_tx_ready_i(tx_ready),
    .per_rx_valid_i(rx_valid), .per_rx_data_i(rx_data), .per_rx_ready_o(rx_ready),
    .busy_o(busy), .slot_o(slot), .chunk_done_o(chunk_done),
    .tx_end_o(tx_end), .rx_end_o(rx_end), .error_o(error));

  typedef struct packed { logic [LW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int nb = 0, nd = 0, nd_base = 0;
  bit one_chunk = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [LW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    it.a = a;
    it.d = d;
    exp_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        nb++;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected tx word at addr", int'(mem_addr), 0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mem_addr == it.a, "R2 R6", "tx address", int'(mem_addr), int'(it.a));
          chk(tx_data == it.d, "R2", "tx data", int'(tx_data), int'(it.d));
        end
      end
      if (mem_wr) begin
        nb++;
        if (exp_q.size() == 0) chk(0, "R3", "unexpected memory write at addr", int'(mem_addr), 0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mem_addr == it.a, "R3 R6", "write address", int'(mem_addr), int'(it.a));
          chk(mem_wdata == it.d, "R3", "write data", int'(mem_wdata), int'(it.d));
        end
      end
      if (chunk_done) begin
        nd++;
        chk(slot == (one_chunk ? 1'b0 : 1'(nd - nd_base)), "R5", "active slot after chunk",
            int'(slot), one_chunk ? 0 : ((nd - nd_base) % 2));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int nb0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(!busy && !error && !tx_end && !rx_end, "R1", "reset idle and flags", int'({busy, error, tx_end, rx_end}), 0);
    chk(!chunk_done && !mem_rd && !rx_ready, "R1", "reset port quiet", int'({chunk_done, mem_rd, rx_ready}), 0);

    // Transmit stream: 16-byte buffer, 4-byte chunks, 20 words
    for (int i = 0; i < 20; i++) push(LW'((i * WB) % 16), pat(LW'((i * WB) % 16)));
    one_chunk = 0; nd_base = nd; nb0 = nb;
    buf_len = 16; chunk_len = 4; dir_rx = 0; tx_ready = 1;
    start = 1; tick(); start = 0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    chk(mem_addr == '0 && slot == 1'b0, "R1 R5", "first offset and slot", int'({slot, mem_addr}), 0);
    while (nb - nb0 < 5) tick();
    dir_rx = 1; start = 1; tick(); start = 0; dir_rx = 0;
    chk(busy && !rx_ready && tx_valid, "R10", "start while busy ignored", int'({busy, rx_ready, tx_valid}), 3'b101);
    while (nb - nb0 < 20) tick();
    tx_ready = 0;
    tick();
    chk(nd - nd_base == 10, "R4", "chunk done pulses for 20 words", nd - nd_base, 10);
    stop = 1; tick(); stop = 0;
    chk(!busy && tx_end && !rx_end, "R7", "stop halts and sets tx end", int'({busy, tx_end, rx_end}), 3'b010);
    chk(exp_q.size() == 0, "R2", "tx words left unsent", exp_q.size(), 0);

    // Resume from offset 0, stalled handshake, then bus error at offset 6
    for (int i = 0; i < 3; i++) push(LW'(i * WB), pat(LW'(i * WB)));
    err_addr = 6; err_en = 1; tx_ready = 0;
    start = 1; tick(); start = 0;
    chk(!tx_end && busy, "R1", "start clears tx end", int'({tx_end, busy}), 1);
    chk(mem_addr == '0, "R7", "restart offset", int'(mem_addr), 0);
    for (int k = 0; k < 6; k++) begin tx_ready = k[0]; tick(); end
    tx_ready = 1;
    for (int k = 0; k < 20 && busy; k++) tick();
    chk(!busy && error && !tx_end, "R8", "error halts and flags", int'({busy, error, tx_end}), 3'b010);
    chk(exp_q.size() == 0, "R8", "words before fault", exp_q.size(), 0);
    err_en = 0; tx_ready = 0;
    repeat (3) tick();
    chk(error == 1'b1, "R8", "error flag sticky", int'(error), 1);

    // Receive stream into a one-chunk buffer of 8 bytes, with gaps
    one_chunk = 1; nd_base = nd;
    buf_len = 8; chunk_len = 8; dir_rx = 1;
    start = 1; tick(); start = 0;
    chk(!error && busy && rx_ready, "R1", "start clears error", int'({error, busy, rx_ready}), 3);
    for (int i = 0; i < 10; i++) begin
      push(LW'((i * WB) % 8), DW'(16'hC000 + i));
      rx_valid = 1; rx_data = DW'(16'hC000 + i); tick();
      if (i % 3 == 2) begin rx_valid = 0; rx_data = DW'(16'hDEAD); tick(); end
    end
    rx_valid = 0;
    tick();
    chk(nd - nd_base == 2, "R4 R5", "chunk done pulses for 10 words", nd - nd_base, 2);
    stop = 1; tick(); stop = 0;
    chk(!busy && rx_end && !tx_end, "R7", "stop sets rx end only", int'({busy, rx_end, tx_end}), 3'b010);
    chk(exp_q.size() == 0, "R3", "rx words missing", exp_q.size(), 0);

    // Single-shot transmit of an 8-byte buffer
    nd_base = nd; one_chunk = 0;
    for (int i = 0; i < 4; i++) push(LW'(i * WB), pat(LW'(i * WB)));
    buf_len = 8; chunk_len = 4; dir_rx = 0; single = 1; tx_ready = 1;
    start = 1; tick(); start = 0; single = 0;
    repeat (8) tick();
    chk(!busy && !tx_end, "R9", "single shot idle without end flag", int'({busy, tx_end}), 0);
    chk(nd == nd_base, "R9", "single shot chunk pulses", nd - nd_base, 0);
    chk(exp_q.size() == 0, "R9", "single shot words left", exp_q.size(), 0);
    tx_ready = 0;

    // Stop while idle
    stop = 1; tick(); stop = 0; tick();
    chk(!busy && !tx_end && rx_end && !error, "R10", "stop while idle", int'({busy, tx_end, rx_end, error}), 4'b0010);

    tick();
    summary();
    $finish;
  end
endmodule